// File: doc/BRIEF.md
# Two-Way Traffic Light Sequencer

This block drives two coupled traffic signals, each with a red, a yellow and a green lamp. A three-bit phase register walks a fixed six-step cycle, moving one step on each cycle where an external pacing strobe is high. The strobe sets the timing, so the same block serves any dwell time that the surrounding logic chooses.

The six lamp outputs come from registers, so they follow the phase one clock later and never glitch. Red on each light is derived as "neither green nor yellow". The two spare phase codes are fault states: they light red on both signals, raise a fault flag, and return to the first phase on the next clock whether or not the strobe is high. A build-time option adds a cross-check that forces a light to red whenever the other light is green or yellow.

Top module: `traffic_pair_seq`

## Requirements
- R1: After reset the phase is 0 (code 000), both lights show red only, and the fault flag is low.
- R2: On a clock edge with the advance strobe high and a legal phase, the phase steps 0→1→2→3→4→5→0; phase n uses the unsigned code n (000 to 101).
- R3: On a clock edge with the advance strobe low and a legal phase, the phase does not change.
- R4: Lamp pattern per phase, given as light 1 / light 2: phase 0 red/red, 1 red/green, 2 red/yellow, 3 red/red, 4 green/red, 5 yellow/red.
- R5: Each light's red lamp is on exactly when its green and yellow lamps are both off; at no time are both lights off red.
- R6: From code 110 or 111 the next phase is 000 on the following clock edge, whatever the advance strobe.
- R7: While the phase code is 110 or 111 the decoded lamps are red on both lights, with no green or yellow.
- R8: The lamp outputs are registered: they show the pattern of the phase held one cycle earlier.
- R9: The fault flag is high exactly while the phase code is 110 or 111.
- R10: With FAULT_TOL set, a light's red lamp is also forced on whenever the other light shows green or yellow; on all eight codes the outputs then still match R4 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| advance | input | 1 | Pacing strobe; one phase step per high cycle |
| r1 | output | 1 | Light 1 red lamp |
| y1 | output | 1 | Light 1 yellow lamp |
| g1 | output | 1 | Light 1 green lamp |
| r2 | output | 1 | Light 2 red lamp |
| y2 | output | 1 | Light 2 yellow lamp |
| g2 | output | 1 | Light 2 green lamp |
| fault | output | 1 | High while the phase register holds a spare code |

## Verification
The wrap from phase 5 back to 0 is run many times under a strobe pattern with runs of high and low cycles; a design that counted to 7 or wrapped early would show the wrong lamps after the fifth step, and one that ignored the strobe would drift ahead of the model. The lamps are sampled one cycle behind the phase, so a decode placed after the register instead of before it shows up as a one-cycle lead. The spare codes cannot be reached from reset, so the decode and next-phase stages are swept over all eight codes in both modes and with the strobe both high and low; a design that let 110 or 111 light green or hold its code when the strobe is low fails there.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int PHASE_W    = 3;
  localparam int NUM_PHASES = 6;
  localparam int LAMP_W     = 6;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [LAMP_W-1:0]  lamp_vec_t;

  localparam phase_t PH_FIRST   = phase_t'(0);
  localparam phase_t PH_LAST    = phase_t'(NUM_PHASES - 1);
  localparam phase_t PH_B_GREEN = phase_t'(1);
  localparam phase_t PH_B_AMBER = phase_t'(2);
  localparam phase_t PH_A_GREEN = phase_t'(4);
  localparam phase_t PH_A_AMBER = phase_t'(5);

  // lamp vector layout {a_red, a_yel, a_grn, b_red, b_yel, b_grn}
  localparam int LA_R = 5;
  localparam int LA_Y = 4;
  localparam int LA_G = 3;
  localparam int LB_R = 2;
  localparam int LB_Y = 1;
  localparam int LB_G = 0;

  localparam lamp_vec_t LAMPS_ALL_RED = lamp_vec_t'(6'b100_100);
endpackage

// File: rtl/tl_rst_sync.sv
module tl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/tl_phase_next.sv
module tl_phase_next
  import tl_pkg::*;
(
  input  phase_t cur,
  input  logic   advance,
  output phase_t nxt,
  output logic   illegal,
  output logic   step_en
);
  always_comb begin
    illegal = (cur > PH_LAST);
    step_en = advance | illegal;
    if (illegal || cur == PH_LAST) nxt = PH_FIRST;
    else                           nxt = phase_t'(cur + 1'b1);
  end

  // R6: every computed successor is a legal phase
  always_comb begin
    a_r6_legal_next: assert (nxt <= PH_LAST);
  end
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
  import tl_pkg::*;
#(
  parameter bit FAULT_TOL = 1'b0
) (
  input  phase_t    phase,
  output lamp_vec_t lamps
);
  logic a_grn, a_yel, b_grn, b_yel;
  logic a_red_base, b_red_base;

  always_comb begin
    a_grn      = (phase == PH_A_GREEN);
    a_yel      = (phase == PH_A_AMBER);
    b_grn      = (phase == PH_B_GREEN);
    b_yel      = (phase == PH_B_AMBER);
    a_red_base = ~(a_grn | a_yel);
    b_red_base = ~(b_grn | b_yel);
  end

  generate
    if (FAULT_TOL) begin : g_cross
      always_comb begin
        lamps       = '0;
        lamps[LA_G] = a_grn;
        lamps[LA_Y] = a_yel;
        lamps[LA_R] = a_red_base | b_grn | b_yel;
        lamps[LB_G] = b_grn;
        lamps[LB_Y] = b_yel;
        lamps[LB_R] = b_red_base | a_grn | a_yel;
      end
    end else begin : g_plain
      always_comb begin
        lamps       = '0;
        lamps[LA_G] = a_grn;
        lamps[LA_Y] = a_yel;
        lamps[LA_R] = a_red_base;
        lamps[LB_G] = b_grn;
        lamps[LB_Y] = b_yel;
        lamps[LB_R] = b_red_base;
      end
    end
  endgenerate

  // R5 / R7: at least one light stays red, spare codes give all red
  always_comb begin
    a_r5_one_red: assert (lamps[LA_R] | lamps[LB_R]);
    a_r7_spare_red: assert (!(phase > PH_LAST) || lamps == LAMPS_ALL_RED);
  end
endmodule

// File: rtl/traffic_pair_seq.sv
module traffic_pair_seq
  import tl_pkg::*;
#(
  parameter bit FAULT_TOL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic r1,
  output logic y1,
  output logic g1,
  output logic r2,
  output logic y2,
  output logic g2,
  output logic fault
);
  logic      srst_n;
  phase_t    state_q, state_d;
  logic      state_en;
  lamp_vec_t lamp_d, lamp_q;

  tl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  tl_phase_next u_next (
    .cur     (state_q),
    .advance (advance),
    .nxt     (state_d),
    .illegal (fault),
    .step_en (state_en)
  );

  tl_lamp_decode #(.FAULT_TOL(FAULT_TOL)) u_dec (
    .phase (state_q),
    .lamps (lamp_d)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       state_q <= PH_FIRST;
    else if (state_en) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lamp_q <= LAMPS_ALL_RED;
    else         lamp_q <= lamp_d;
  end

  assign r1 = lamp_q[LA_R];
  assign y1 = lamp_q[LA_Y];
  assign g1 = lamp_q[LA_G];
  assign r2 = lamp_q[LB_R];
  assign y2 = lamp_q[LB_Y];
  assign g2 = lamp_q[LB_G];

  // R3: no strobe on a legal phase holds the phase
  a_r3_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!advance && !fault) |=> $stable(state_q));

  // R2: strobe on a legal non-final phase moves one step up
  a_r2_step: assert property (@(posedge clk) disable iff (!srst_n)
    (advance && !fault && state_q != PH_LAST) |=> state_q == phase_t'($past(state_q) + 1'b1));

  // R6: spare code returns to phase 0
  a_r6_recover: assert property (@(posedge clk) disable iff (!srst_n)
    fault |=> state_q == PH_FIRST);

  // R7 / R8: a spare code shows as all red one cycle later
  a_r7_red_after_fault: assert property (@(posedge clk) disable iff (!srst_n)
    fault |=> (r1 && r2 && !g1 && !y1 && !g2 && !y2));

  // R5: one lamp per light at the outputs
  a_r5_one_lamp: assert property (@(posedge clk) disable iff (!srst_n)
    ($countones({r1, y1, g1}) == 1) && ($countones({r2, y2, g2}) == 1));
endmodule

// File: tb/test_traffic_pair_seq.sv
module test_traffic_pair_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic advance = 1'b0;
  logic r1, y1, g1, r2, y2, g2, fault;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  traffic_pair_seq #(.FAULT_TOL(1'b0)) i_traffic_pair_seq (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .r1(r1), .y1(y1), .g1(g1), .r2(r2), .y2(y2), .g2(g2), .fault(fault)
  );

  // stage-level sweeps over all eight codes
  logic [2:0] sw_code;
  logic       sw_adv;
  logic [2:0] sw_nxt;
  logic       sw_ill, sw_en;
  logic [5:0] sw_l0, sw_l1;

  tl_phase_next i_next (.cur(sw_code), .advance(sw_adv), .nxt(sw_nxt),
                        .illegal(sw_ill), .step_en(sw_en));
  tl_lamp_decode #(.FAULT_TOL(1'b0)) i_dec0 (.phase(sw_code), .lamps(sw_l0));
  tl_lamp_decode #(.FAULT_TOL(1'b1)) i_dec1 (.phase(sw_code), .lamps(sw_l1));

  // expected {r1,y1,g1,r2,y2,g2} for a code, from R4 and R7
  function automatic logic [5:0] exp_lamps(input int c);
    case (c)
      1:       return 6'b100_001;
      2:       return 6'b100_010;
      4:       return 6'b001_100;
      5:       return 6'b010_100;
      default: return 6'b100_100;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {r1, y1, g1, r2, y2, g2};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int st;
    logic [5:0] lexp;
    sw_code = '0;
    sw_adv  = 1'b0;

    // stage sweeps: R6 R7 R9 R10 R4
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 2; a++) begin
        sw_code = 3'(c);
        sw_adv  = a[0];
        #1;
        if (c > 5) begin
          check(sw_nxt == 3'd0 && sw_en, "R6 spare code next", {sw_en, sw_nxt}, 4'b1000);
        end else if (a == 1) begin
          check(sw_nxt == 3'((c + 1) % 6) && sw_en, "R2 next phase", {sw_en, sw_nxt}, {1'b1, 3'((c + 1) % 6)});
        end else begin
          check(!sw_en, "R3 no step without strobe", sw_en, 0);
        end
        check(sw_ill == (c > 5), "R9 fault decode", sw_ill, c > 5);
        check(sw_l0 == exp_lamps(c), "R4 R7 lamp decode", sw_l0, exp_lamps(c));
        check(sw_l1 == exp_lamps(c), "R10 cross-check mode decode", sw_l1, exp_lamps(c));
      end
    end

    // reset: R1
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(outs() == 6'b100_100, "R1 reset lamps", outs(), 6'b100_100);
    check(!fault, "R1 reset fault", fault, 0);

    // strobe patterns: R2 R3 R4 R5 R8 R9
    st = 0;
    for (int i = 0; i < 120; i++) begin
      advance = (i < 40) ? 1'b1 : ((i < 80) ? ((i % 3) != 0) : ((i % 5) == 1));
      @(posedge clk);
      lexp = exp_lamps(st);
      if (advance) st = (st + 1) % 6;
      @(negedge clk);
      check(outs() == lexp, "R8 R4 lamps lag phase", outs(), lexp);
      check(!fault, "R9 no fault on legal phase", fault, 0);
      check(($countones({r1, y1, g1}) == 1) && ($countones({r2, y2, g2}) == 1),
            "R5 one lamp per light", outs(), lexp);
    end
    // one more idle cycle: lamps now show the final phase, R3 holds it
    advance = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(outs() == exp_lamps(st), "R3 hold final phase", outs(), exp_lamps(st));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule